// File: doc/BRIEF.md
# Five-Phase Instruction Timing Sequencer

This block sets the timing of a multi-cycle processor control path. A small binary counter steps once per enabled clock. A decoder turns each count value into its own phase strobe. The five strobes cover the steps of one instruction. Fetch comes first. Next is decode with the register operand read, then the ALU operation, then the memory access, and last the register write-back.

When the count reaches the last phase, a combinational detector drives the counter's synchronous clear. The next enabled edge then loads zero, so the sequence runs 0,1,2,3,4,0,1,... without end. An active-low synchronous reset puts the sequencer back at Fetch. An enable input freezes the phase while it is low. Downstream control logic qualifies its datapath controls with the strobes, but that logic is not part of this block.

Top module: `phase_sequencer`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` becomes 0 after that edge, and `phase_strb` becomes 5'b00001 (Fetch).
- R2: When `rst_n` is high, `en` is high and `count` is below 4 at a rising edge, `count` goes up by exactly one after that edge.
- R3: When `rst_n` is high, `en` is high and `count` is 4 at a rising edge, `count` becomes 0 after that edge. The values 5 to 15 never appear after reset.
- R4: When `rst_n` is high and `en` is low at a rising edge, `count` and `phase_strb` keep their values across that edge.
- R5: In every cycle after the first reset, exactly one bit of `phase_strb` is high.
- R6: Bit k of `phase_strb` is high exactly when `count` equals k. The bits are: bit 0 Fetch, bit 1 decode/register read, bit 2 ALU operation, bit 3 memory access, bit 4 register write-back.
- R7: A low `rst_n` takes priority over `en`. With both asserted at an edge, the count still goes to 0 and not to the next phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable; holds the phase when low |
| count | output | 4 | Current phase count, 0 to 4 |
| phase_strb | output | 5 | One-hot phase strobes, bit 0 Fetch through bit 4 write-back |

## Verification
The bench targets the wrap from count 4. A design that compared against the wrong terminal value would either show count 5 with no strobe high, or cut the sequence one phase short. It also stalls the sequencer with enable low while in the last phase. A design that let the terminal clear bypass the enable would drop back to Fetch while it should be holding. Finally, the bench asserts reset together with enable in the middle of the sequence. A design that ranked enable above reset would advance instead of returning to Fetch, and any decoder slip would show up as a strobe bit out of step with the count.

// File: rtl/phase_seq_pkg.sv
// Package: shared sizing for the phase sequencer.
// Assumes: the counter is wide enough to hold NUM_PHASES-1.
package phase_seq_pkg;
    localparam int unsigned SEQ_CNT_W  = 4;
    localparam int unsigned SEQ_PHASES = 5;
    // Strobe bit positions, in instruction order
    localparam int unsigned PH_FETCH  = 0;
    localparam int unsigned PH_DECODE = 1;
    localparam int unsigned PH_ALU    = 2;
    localparam int unsigned PH_MEM    = 3;
    localparam int unsigned PH_WBACK  = 4;
endpackage

// File: rtl/phase_term_detect.sv
// Module: phase_term_detect
// Purpose: flags the count value of the final phase, which feeds the
// counter's synchronous clear.
// Assumes: count never exceeds the final phase once reset has been applied.
module phase_term_detect #(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned NUM_PHASES = 5
) (
    input  logic [CNT_W-1:0] count,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PHASES - 1);

    // Compare the count against the terminal value
    always_comb begin
        at_last = (count == LAST);
    end
endmodule

// File: rtl/phase_counter.sv
// Module: phase_counter
// Purpose: binary counter that steps on each enabled edge and clears when
// the terminal flag is set. Reset is synchronous and active low, and it
// wins over enable.
// Assumes: wrap_clr is driven combinationally from the current count.
module phase_counter #(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned NUM_PHASES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap_clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PHASES - 1);

    // Count register: reset, then hold, clear or increment
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (!en)      count <= count;
        else if (wrap_clr) count <= '0;
        else               count <= count + CNT_W'(1);
    end

    // R1 R7
    reset_to_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));
    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count != LAST) |=> (count == $past(count) + CNT_W'(1)));
    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == LAST) |=> (count == '0));
    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
endmodule

// File: rtl/phase_decoder.sv
// Module: phase_decoder
// Purpose: turns the count into one strobe per phase.
// Assumes: count stays inside 0..NUM_PHASES-1. The clock and reset are
// used only by the checks.
module phase_decoder #(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned NUM_PHASES = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      count,
    output logic [NUM_PHASES-1:0] strobe
);
    // One comparator per phase strobe
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_ph
        assign strobe[k] = (count == CNT_W'(k));
    end

    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe) == 1);
endmodule

// File: rtl/phase_sequencer.sv
// Module: phase_sequencer
// Purpose: top of the timing generator. A terminal-count detector feeds a
// counter's clear, and a decoder drives the one-hot phase strobes.
// Assumes: rst_n is held low for at least one clock edge before use.
module phase_sequencer
    import phase_seq_pkg::*;
#(
    parameter int unsigned CNT_W      = SEQ_CNT_W,
    parameter int unsigned NUM_PHASES = SEQ_PHASES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    output logic [CNT_W-1:0]      count,
    output logic [NUM_PHASES-1:0] phase_strb
);
    logic at_last;

    phase_term_detect #(.CNT_W(CNT_W), .NUM_PHASES(NUM_PHASES)) u_term (
        .count   (count),
        .at_last (at_last)
    );

    phase_counter #(.CNT_W(CNT_W), .NUM_PHASES(NUM_PHASES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wrap_clr (at_last),
        .count    (count)
    );

    phase_decoder #(.CNT_W(CNT_W), .NUM_PHASES(NUM_PHASES)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (count),
        .strobe (phase_strb)
    );

    // R3 R6
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_strb[NUM_PHASES-1]) |=> phase_strb[PH_FETCH]);
    // R4 R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase_strb));
endmodule

// File: tb/phase_sequencer_tb.sv
`timescale 1ns/1ps
module phase_sequencer_tb;
    localparam int CW = 4;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] count;
    logic [NP-1:0] phase_strb;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [CW-1:0] exp_cnt = '0;

    always #4 clk = ~clk;

    phase_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .count      (count),
        .phase_strb (phase_strb)
    );

    function automatic logic [CW-1:0] next_cnt(logic [CW-1:0] c, bit r, bit e);
        if (!r) return '0;
        if (!e) return c;
        if (c == CW'(NP - 1)) return '0;
        return c + CW'(1);
    endfunction

    function automatic logic [NP-1:0] strb_of(logic [CW-1:0] c);
        return NP'(1) << c;
    endfunction

    task automatic check_out(string req);
        checks++;
        if (count !== exp_cnt) begin
            fails++;
            $display("FAIL %s count actual=%0d expected=%0d", req, count, exp_cnt);
        end
        checks++;
        if (phase_strb !== strb_of(exp_cnt)) begin
            fails++;
            $display("FAIL R6 strobe actual=%b expected=%b", phase_strb, strb_of(exp_cnt));
        end
        checks++;
        if ($countones(phase_strb) != 1) begin
            fails++;
            $display("FAIL R5 ones actual=%0d expected=1", $countones(phase_strb));
        end
    endtask

    // One cycle: drive at negedge, let an edge pass, check at next negedge
    task automatic step(bit r, bit e);
        string req;
        if (!r)                         req = (e ? "R7" : "R1");
        else if (!e)                    req = "R4";
        else if (exp_cnt == CW'(NP - 1)) req = "R3";
        else                            req = "R2";
        rst_n = r;
        en    = e;
        @(posedge clk);
        exp_cnt = next_cnt(exp_cnt, r, e);
        @(negedge clk);
        check_out(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset state
        step(1'b0, 1'b0);
        // R2 R3 two full laps
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
        // go to phase 4, then R4 hold at terminal count
        while (exp_cnt != CW'(NP - 1)) step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);   // R3 wrap after the hold
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // R7 reset while enabled in mid-sequence
        step(1'b0, 1'b1);
        // random mix
        for (int i = 0; i < 2000; i++) begin
            bit r = ($urandom_range(0, 99) >= 4);
            bit e = ($urandom_range(0, 99) < 75);
            step(r, e);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule